// File: doc/BRIEF.md
# Move-Only Transport Processor Core

This block is a small processor core with a single kind of instruction: a data move. A wide instruction word holds one move slot for each transport bus. Each slot names where a value comes from and where it goes. Values come from register-file read ports, function-unit result ports, or a constant carried in the slot. Values go to register-file write ports, function-unit operand or trigger ports, or an output port. No opcode is decoded. A unit computes only when a value is moved onto one of its trigger ports, and the trigger port that is written selects the operation.

The core fetches one instruction word per clock from an external program store. It presents the fetch address on `pc_o` and takes the word for that address on `instr_i` in the same cycle. All slots of a word run in that cycle, and every destination latches at the closing clock edge. Results leave the core through the output port, which pulses a valid flag with the moved value. The core has no branching, no data memory and no instruction compression.

Top module: `tta_move_core`

## Requirements
- R1: A synchronous active-high `rst` sets `pc_o` to 0, `out_valid_o` to 0, `out_data_o` to 0, and all registers and unit state to 0. Outside reset, `pc_o` increases by one on every clock, wrapping at its width.
- R2: Bus b takes bits [16b+15:16b] of `instr_i`. Inside a slot, bit 15 is valid, bits 14:11 are the source ID, bits 10:7 are the destination ID and bits 6:0 are the immediate. Every slot of one word runs in the same cycle.
- R3: The source IDs are: 0-7 for registers r0-r7, 8 for the adder unit result, 9 for the logic unit result, and 10 for the immediate, sign-extended from 7 bits to 16. Source IDs 11-15 are unconnected, and a slot that uses one makes no transfer.
- R4: The destination IDs are: 0-7 for registers r0-r7; 9 for the adder operand; 10 for the adder add trigger (result = operand + value); 11 for the adder subtract trigger (result = operand - value); 12 for the logic operand; 13 for the AND trigger; 14 for the XOR trigger; and 15 for the output port. Destination ID 8 is unconnected, and a slot that uses it makes no transfer.
- R5: Writing a trigger computes the unit result at the end of that cycle. The result can be used as a source from the next instruction onward. If the unit's operand is written in the same instruction, the new operand value is used.
- R6: Writing an operand port only latches the value. The unit result changes only when a trigger is written.
- R7: A register write takes effect at the end of the cycle. A read of the same register in that cycle returns the old value.
- R8: When several slots of one word target the same register, the same operand port, the output port, or any trigger of the same unit, the slot on the higher-numbered bus wins.
- R9: A slot whose valid bit is 0 makes no transfer and changes no state.
- R10: A move to the output port sets `out_valid_o` high for exactly the next cycle, with `out_data_o` equal to the moved value. `out_data_o` holds its value between such moves.
- R11: A unit result used as a source can feed another unit's operand or trigger port directly, without passing through a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word for the current `pc_o`, one 16-bit slot per bus |
| pc_o | output | 6 | Fetch address |
| out_valid_o | output | 1 | Output port written in the previous cycle |
| out_data_o | output | 16 | Last value moved to the output port |

## Verification
The bench targets cases where timing and priority are easy to get wrong:
- A register read in the cycle it is written must return the old value. A design with a write-through path would return the new value early.
- An operand and a trigger of the same unit written in one word must use the new operand. A design without that forwarding would compute with a stale operand.
- Two buses that target the same register, the output port, or two triggers of the same unit must resolve to the higher bus. A reversed priority would show the lower bus's value or operation.
- Invalid slots, unconnected IDs and operand-only writes must leave registers, results and the output port unchanged. A design that ignores the valid bit or the connection map would corrupt a later read-back.

// File: rtl/tta_pkg.sv
`timescale 1ns/1ps
package tta_pkg;
  localparam int SLOT_W = 16;
  localparam int ID_W   = 4;
  localparam int IMM_W  = 7;
  localparam int NREG   = 8;
  localparam int RA_W   = 3;

  typedef struct packed {
    logic             vld;
    logic [ID_W-1:0]  src;
    logic [ID_W-1:0]  dst;
    logic [IMM_W-1:0] imm;
  } slot_t;

  // socket map: result ports sit after the registers, immediate after results
  localparam logic [ID_W-1:0] SRC_RES0 = 4'd8;
  localparam logic [ID_W-1:0] DST_FU0  = 4'd9;   // each unit: operand, trig0, trig1
  localparam logic [ID_W-1:0] DST_OUT  = 4'd15;
  localparam logic [ID_W-1:0] DST_NONE = 4'd8;
endpackage

// File: rtl/tta_slot_dec.sv
`timescale 1ns/1ps
module tta_slot_dec
  import tta_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NFU = 2
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              vld_o,
  output logic [ID_W-1:0]   src_o,
  output logic [ID_W-1:0]   dst_o,
  output logic [DW-1:0]     imm_o,
  output logic              src_ok_o,
  output logic              dst_ok_o
);
  localparam int SRC_LAST = NREG + NFU;  // immediate ID

  slot_t s;
  assign s     = slot_t'(slot_i);
  assign vld_o = s.vld;
  assign src_o = s.src;
  assign dst_o = s.dst;

  function automatic logic [DW-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  assign imm_o    = sext_imm(s.imm);
  assign src_ok_o = (int'(s.src) <= SRC_LAST);
  assign dst_ok_o = (s.dst != DST_NONE);
endmodule

// File: rtl/tta_regfile.sv
`timescale 1ns/1ps
module tta_regfile #(
  parameter int NP   = 2,
  parameter int DW   = 16,
  parameter int NR   = 8,
  localparam int AW  = $clog2(NR)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0][AW-1:0]  raddr_i,
  output logic [NP-1:0][DW-1:0]  rdata_o,
  input  logic [NP-1:0]          we_i,
  input  logic [NP-1:0][AW-1:0]  waddr_i,
  input  logic [NP-1:0][DW-1:0]  wdata_i
);
  logic [NR-1:0][DW-1:0] mem_q;

  // later ports override earlier ones: highest bus wins
  always_ff @(posedge clk) begin
    if (rst) mem_q <= '0;
    else begin
      for (int p = 0; p < NP; p++)
        if (we_i[p]) mem_q[waddr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

  AST_RF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|we_i) |=> $stable(mem_q)); // R7

  if (NP > 1) begin : g_prio_chk
    AST_RF_PRIO: assert property (@(posedge clk) disable iff (rst)
      (we_i[0] && we_i[NP-1] && waddr_i[0] == waddr_i[NP-1])
      |=> mem_q[$past(waddr_i[NP-1])] == $past(wdata_i[NP-1])); // R8
  end
endmodule

// File: rtl/tta_fu.sv
`timescale 1ns/1ps
module tta_fu #(
  parameter int DW   = 16,
  parameter int KIND = 0      // 0: add/sub, 1: and/xor
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_we_i,
  input  logic [DW-1:0] op_d_i,
  input  logic          trig_we_i,
  input  logic          trig_sel_i,
  input  logic [DW-1:0] trig_d_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] op_q, op_eff, res_q;

  function automatic logic [DW-1:0] fu_calc(input logic sel,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    if (KIND == 0) return sel ? (a - b) : (a + b);
    else           return sel ? (a ^ b) : (a & b);
  endfunction

  // an operand moved in the same word as the trigger is used at once
  assign op_eff = op_we_i ? op_d_i : op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      res_q <= '0;
    end else begin
      if (op_we_i)   op_q  <= op_d_i;
      if (trig_we_i) res_q <= fu_calc(trig_sel_i, op_eff, trig_d_i);
    end
  end

  assign res_o = res_q;

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !trig_we_i |=> $stable(res_q)); // R6
endmodule

// File: rtl/tta_move_core.sv
`timescale 1ns/1ps
module tta_move_core
  import tta_pkg::*;
#(
  parameter int NBUS = 2,
  parameter int DW   = 16,
  parameter int PCW  = 6,
  parameter int NFU  = 2,
  localparam int IW  = NBUS * SLOT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  instr_i,
  output logic [PCW-1:0] pc_o,
  output logic           out_valid_o,
  output logic [DW-1:0]  out_data_o
);
  logic [PCW-1:0] pc_q;

  logic [NBUS-1:0]           s_vld, s_src_ok, s_dst_ok, mv;
  logic [NBUS-1:0][ID_W-1:0] s_src, s_dst;
  logic [NBUS-1:0][DW-1:0]   s_imm, bus_val, rf_rd;
  logic [NBUS-1:0][RA_W-1:0] rf_ra, rf_wa;
  logic [NBUS-1:0]           rf_we;
  logic [NFU-1:0][DW-1:0]    fu_res;

  logic          out_hit;
  logic [DW-1:0] out_d, out_data_q;
  logic          out_valid_q;

  // fetch counter
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end
  assign pc_o = pc_q;

  // per-bus slot decode and source socket
  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    tta_slot_dec #(.DW(DW), .NFU(NFU)) i_dec (
      .slot_i  (instr_i[b*SLOT_W +: SLOT_W]),
      .vld_o   (s_vld[b]),
      .src_o   (s_src[b]),
      .dst_o   (s_dst[b]),
      .imm_o   (s_imm[b]),
      .src_ok_o(s_src_ok[b]),
      .dst_ok_o(s_dst_ok[b])
    );

    assign rf_ra[b] = s_src[b][RA_W-1:0];
    assign mv[b]    = s_vld[b] && s_src_ok[b] && s_dst_ok[b];

    always_comb begin
      if (int'(s_src[b]) < NREG)            bus_val[b] = rf_rd[b];
      else if (int'(s_src[b]) < NREG + NFU) bus_val[b] = fu_res[int'(s_src[b]) - NREG];
      else                                  bus_val[b] = s_imm[b];
    end

    assign rf_we[b] = mv[b] && (int'(s_dst[b]) < NREG);
    assign rf_wa[b] = s_dst[b][RA_W-1:0];
  end

  tta_regfile #(.NP(NBUS), .DW(DW), .NR(NREG)) i_rf (
    .clk    (clk),
    .rst    (rst),
    .raddr_i(rf_ra),
    .rdata_o(rf_rd),
    .we_i   (rf_we),
    .waddr_i(rf_wa),
    .wdata_i(bus_val)
  );

  // function units with their destination sockets
  for (genvar k = 0; k < NFU; k++) begin : g_fu
    localparam logic [ID_W-1:0] BASE = ID_W'(int'(DST_FU0) + 3 * k);
    logic          op_we, trig_we, trig_sel;
    logic [DW-1:0] op_d, trig_d;

    always_comb begin
      op_we = 1'b0; op_d = '0;
      trig_we = 1'b0; trig_sel = 1'b0; trig_d = '0;
      for (int b = 0; b < NBUS; b++) begin
        if (mv[b] && s_dst[b] == BASE) begin
          op_we = 1'b1; op_d = bus_val[b];
        end
        if (mv[b] && (s_dst[b] == BASE + 1 || s_dst[b] == BASE + 2)) begin
          trig_we = 1'b1; trig_d = bus_val[b];
          trig_sel = (s_dst[b] == BASE + 2);
        end
      end
    end

    tta_fu #(.DW(DW), .KIND(k)) i_fu (
      .clk       (clk),
      .rst       (rst),
      .op_we_i   (op_we),
      .op_d_i    (op_d),
      .trig_we_i (trig_we),
      .trig_sel_i(trig_sel),
      .trig_d_i  (trig_d),
      .res_o     (fu_res[k])
    );
  end

  // output port socket
  always_comb begin
    out_hit = 1'b0; out_d = '0;
    for (int b = 0; b < NBUS; b++)
      if (mv[b] && s_dst[b] == DST_OUT) begin
        out_hit = 1'b1; out_d = bus_val[b];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= out_hit;
      if (out_hit) out_data_q <= out_d;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_o == PCW'($past(pc_o) + 1'b1)); // R1
  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|s_vld) |=> !out_valid_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_hit |=> $stable(out_data_o)); // R10
endmodule

// File: tb/test_tta_move_core.sv
`timescale 1ns/1ps
module test_tta_move_core;
  localparam int NROW = 24;
  localparam logic [15:0] NOP = 16'h0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr;
  logic [5:0]  pc;
  logic        ov;
  logic [15:0] od;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  // row: {bus1 slot, bus0 slot, expected valid, expected data}
  // slot: {valid, src[3:0], dst[3:0], imm[6:0]}
  localparam logic [48:0] TBL [NROW] = '{
    {{1'b1,4'd10,4'd2,7'h7D}, {1'b1,4'd10,4'd1,7'd5},  1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd1,4'd15,7'd0},  1'b1, 16'h0005},
    {NOP,                     {1'b1,4'd2,4'd15,7'd0},  1'b1, 16'hFFFD},
    {{1'b1,4'd2,4'd10,7'd0},  {1'b1,4'd1,4'd9,7'd0},   1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd8,4'd15,7'd0},  1'b1, 16'h0002},
    {{1'b1,4'd10,4'd11,7'd6}, {1'b1,4'd10,4'd9,7'd20}, 1'b0, 16'h0000},
    {{1'b1,4'd10,4'd13,7'd11},{1'b1,4'd8,4'd12,7'd0},  1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd9,4'd15,7'd0},  1'b1, 16'h000A},
    {{1'b1,4'd8,4'd14,7'd0},  {1'b1,4'd10,4'd12,7'd3}, 1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd9,4'd15,7'd0},  1'b1, 16'h000D},
    {{1'b1,4'd1,4'd15,7'd0},  {1'b1,4'd10,4'd1,7'd9},  1'b1, 16'h0005},
    {NOP,                     {1'b1,4'd1,4'd15,7'd0},  1'b1, 16'h0009},
    {{1'b1,4'd10,4'd3,7'd2},  {1'b1,4'd10,4'd3,7'd1},  1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd3,4'd15,7'd0},  1'b1, 16'h0002},
    {{1'b1,4'd10,4'd15,7'd7}, {1'b1,4'd10,4'd15,7'd4}, 1'b1, 16'h0007},
    {{1'b0,4'd10,4'd3,7'd50}, {1'b0,4'd10,4'd15,7'd33},1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd3,4'd15,7'd0},  1'b1, 16'h0002},
    {{1'b1,4'd10,4'd8,7'd5},  {1'b1,4'd12,4'd3,7'd0},  1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd3,4'd15,7'd0},  1'b1, 16'h0002},
    {NOP,                     {1'b1,4'd10,4'd9,7'd50}, 1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd8,4'd15,7'd0},  1'b1, 16'h000E},
    {{1'b1,4'd10,4'd11,7'd10},{1'b1,4'd10,4'd10,7'd1}, 1'b0, 16'h0000},
    {NOP,                     {1'b1,4'd8,4'd15,7'd0},  1'b1, 16'h0028},
    {NOP,                     {1'b1,4'd10,4'd15,7'h40},1'b1, 16'hFFC0}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1, 2:   return "R2";
      3:         return "R5";
      4:         return "R4";
      5, 6, 7:   return "R11";
      8, 9:      return "R5";
      10, 11:    return "R7";
      12, 13, 14: return "R8";
      15, 16:    return "R9";
      17, 18:    return "R3";
      19, 20:    return "R6";
      21, 22:    return "R8";
      default:   return "R3";
    endcase
  endfunction

  assign instr = (int'(pc) < NROW) ? TBL[pc][48:17] : 32'h0;

  tta_move_core i_tta_move_core (
    .clk        (clk),
    .rst        (rst),
    .instr_i    (instr),
    .pc_o       (pc),
    .out_valid_o(ov),
    .out_data_o (od)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    logic [15:0] last_d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc == 6'd0, "R1 pc in reset", 32'(pc), 0);
    chk(ov == 1'b0, "R1 out_valid in reset", 32'(ov), 0);
    chk(od == 16'h0, "R1 out_data in reset", 32'(od), 0);
    rst = 1'b0;
    last_d = 16'h0;
    for (int k = 0; k < NROW; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(pc == 6'(k + 1), "R1 pc step", 32'(pc), 32'(k + 1));
      chk(ov == TBL[k][16], {row_req(k), " out_valid"}, 32'(ov), 32'(TBL[k][16]));
      if (TBL[k][16]) begin
        chk(od == TBL[k][15:0], {row_req(k), " out_data"}, 32'(od), 32'(TBL[k][15:0]));
        last_d = TBL[k][15:0];
      end else begin
        chk(od == last_d, "R10 out_data hold", 32'(od), 32'(last_d));
      end
    end
    // idle words past the table: output port stays quiet
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ov == 1'b0, "R10 single-cycle pulse", 32'(ov), 0);
    chk(od == 16'hFFC0, "R10 data held", 32'(od), 32'hFFC0);
    // reset in the middle of a run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pc == 6'd0, "R1 pc after mid reset", 32'(pc), 0);
    chk(od == 16'h0, "R1 out_data after mid reset", 32'(od), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pc == 6'd1, "R1 pc restarts", 32'(pc), 1);
    @(posedge clk);
    @(negedge clk);
    chk(ov == 1'b1 && od == 16'h0005, "R2 rerun first output", 32'(od), 5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule